// File: doc/BRIEF.md
# Converter Start-up and Protection Supervisor

This block decides, for a switching DC-to-DC converter, which agent may drive the power switches and whether any switching is allowed at all. It takes digitized comparator flags (input battery good, output high enough for normal regulation, output above the stop level, die over-temperature, die cooled) together with a shut-down request and a PWM-mode indication. It produces an enable for a simple start-up pulse path, an enable for the main regulating controller, a soft-start current-limit select and a both-switches-off override.

Start-up switching begins once the battery flag is good and runs from a built-in pulse generator whose on and off lengths are inputs. When the output reaches the regulation level, control moves to the main controller. A sag below that level falls back to start-up; a fall of the output below the stop level halts all switching until a shut-down cycle. Over-temperature halts switching only in PWM mode and releases only on the separate cooled flag. Every threshold flag passes a run-length filter before the state machine sees it, and that filtering continues during shut-down.

Top module: `conv_start_supervisor`

## Requirements
- R1: A flag change reaches the state machine only after the raw flag has held its new value for FILT_LEN (default 4) consecutive clock samples; a shorter run is ignored. With the default, the outputs change at the fifth rising edge after the raw flag changes.
- R2: After reset the block is idle: sw_off_o=1 and su_en_o, main_en_o, soft_lim_o, su_pulse_o are all 0, and it stays so until the filtered battery flag is good.
- R3: From idle a good filtered battery flag enters start-up: su_en_o=1, soft_lim_o=1, sw_off_o=0, main_en_o=0. Losing the filtered battery flag during start-up returns to idle.
- R4: In start-up su_pulse_o begins with an on phase at entry, stays 1 for su_on_len_i cycles, then 0 for su_off_len_i cycles, repeating; a length of 0 acts as 1. It is 0 outside start-up.
- R5: A good filtered regulation flag in start-up hands over to the controller: main_en_o=1 with su_en_o, soft_lim_o, su_pulse_o and sw_off_o all 0.
- R6: Losing the filtered regulation flag while regulating returns to start-up (su_en_o=1, main_en_o=0).
- R7: A 1-to-0 change of the filtered stop-level flag during start-up, regulation or thermal halt enters a halted state with sw_off_o=1 and both enables 0; the halted state is left only through shut-down.
- R8: shdn_i=1 gives sw_off_o=1 with both enables and the pulse at 0 from the next clock edge, whatever the state.
- R9: Release of shut-down always passes through idle and start-up; main_en_o stays 0 for at least two edges after shdn_i falls, even with every flag good.
- R10: The battery flag filter keeps running during shut-down: if the battery flag was good throughout shut-down, start-up begins at the second edge after release.
- R11: With pwm_mode_i=1, a filtered over-temperature flag while regulating halts switching (sw_off_o=1); with pwm_mode_i=0 it is ignored.
- R12: The thermal halt ends only when the filtered cooled flag is 1, then re-enters start-up; clearing the over-temperature flag alone does not end it.
- R13: When events coincide in one cycle, the stop-level fall wins over over-temperature, which wins over loss of regulation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bat_ok_i | input | 1 | Raw battery-good flag |
| reg_ok_i | input | 1 | Raw output-at-regulation-level flag |
| above_stop_i | input | 1 | Raw output-above-stop-level flag |
| hot_i | input | 1 | Raw die over-temperature flag |
| cool_i | input | 1 | Raw die cooled flag |
| shdn_i | input | 1 | Shut-down request, active high |
| pwm_mode_i | input | 1 | Converter is in PWM mode |
| su_on_len_i | input | LEN_W | Start-up pulse on length in cycles |
| su_off_len_i | input | LEN_W | Start-up pulse off length in cycles |
| su_en_o | output | 1 | Start-up path enable |
| main_en_o | output | 1 | Regulating controller enable |
| sw_off_o | output | 1 | Force both switches off |
| soft_lim_o | output | 1 | Select reduced soft-start current limit |
| su_pulse_o | output | 1 | Start-up switch drive pulse |

## Verification
While regulating, loss of regulation can coincide with the over-temperature trip, and either can coincide with the stop-level fall. The bench changes both raw flags at the same falling edge so that their filters flip at the same edge and the state machine sees both events in one cycle. It then judges which state was taken from the ports: the cooled flag is raised afterwards, and only a thermal halt answers by re-entering start-up, while a stop halt stays dark.

// File: rtl/conv_sup_pkg.sv
package conv_sup_pkg;

    localparam int NUM_FLAGS = 5;
    localparam int FL_BAT    = 0;
    localparam int FL_REG    = 1;
    localparam int FL_STOP   = 2;
    localparam int FL_HOT    = 3;
    localparam int FL_COOL   = 4;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_RUN   = 3'd2,
        ST_HOT   = 3'd3,
        ST_HALT  = 3'd4,
        ST_SHDN  = 3'd5
    } sup_state_e;

    typedef struct packed {
        sup_state_e state;
        logic       stop_prev;
    } sup_fsm_t;

endpackage

// File: rtl/sup_flag_filter.sv
module sup_flag_filter #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic flt_o
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

    typedef struct packed {
        logic          val;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (raw_i != cur_q.val) begin
            if (cur_q.cnt == CW'(LEN - 1)) begin
                nxt_d.val = raw_i;
                nxt_d.cnt = '0;
            end else begin
                nxt_d.cnt = cur_q.cnt + 1'b1;
            end
        end else begin
            nxt_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign flt_o = cur_q.val;
endmodule

// File: rtl/sup_pulse_gen.sv
module sup_pulse_gen #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             gate_i,
    input  logic [LEN_W-1:0] on_len_i,
    input  logic [LEN_W-1:0] off_len_i,
    output logic             pulse_o
);
    typedef struct packed {
        logic             phase_on;
        logic [LEN_W-1:0] cnt;
    } pg_t;

    pg_t cur_q, nxt_d;
    logic [LEN_W-1:0] lim;
    logic [LEN_W-1:0] last;

    always_comb begin
        nxt_d = cur_q;
        lim   = cur_q.phase_on ? on_len_i : off_len_i;
        last  = (lim == '0) ? '0 : lim - 1'b1;
        if (!run_i) begin
            nxt_d.phase_on = 1'b1;
            nxt_d.cnt      = '0;
        end else if (cur_q.cnt >= last) begin
            nxt_d.phase_on = ~cur_q.phase_on;
            nxt_d.cnt      = '0;
        end else begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{phase_on: 1'b1, cnt: '0};
        else        cur_q <= nxt_d;
    end

    assign pulse_o = run_i & cur_q.phase_on & ~gate_i;
endmodule

// File: rtl/sup_state_ctrl.sv
module sup_state_ctrl
    import conv_sup_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] flags_i,
    input  logic                 shdn_i,
    input  logic                 pwm_mode_i,
    output logic                 su_en_o,
    output logic                 main_en_o,
    output logic                 sw_off_o,
    output logic                 soft_lim_o
);
    sup_fsm_t cur_q, nxt_d;
    logic bat_f, reg_f, stop_f, hot_f, cool_f, stop_fall;

    assign bat_f  = flags_i[FL_BAT];
    assign reg_f  = flags_i[FL_REG];
    assign stop_f = flags_i[FL_STOP];
    assign hot_f  = flags_i[FL_HOT];
    assign cool_f = flags_i[FL_COOL];
    assign stop_fall = cur_q.stop_prev & ~stop_f;

    always_comb begin
        nxt_d           = cur_q;
        nxt_d.stop_prev = stop_f;
        if (shdn_i) begin
            nxt_d.state = ST_SHDN;
        end else begin
            unique case (cur_q.state)
                ST_SHDN:  nxt_d.state = ST_IDLE;
                ST_IDLE:  if (bat_f) nxt_d.state = ST_START;
                ST_START: begin
                    if (stop_fall)   nxt_d.state = ST_HALT;
                    else if (!bat_f) nxt_d.state = ST_IDLE;
                    else if (reg_f)  nxt_d.state = ST_RUN;
                end
                ST_RUN: begin
                    if (stop_fall)                nxt_d.state = ST_HALT;
                    else if (pwm_mode_i && hot_f) nxt_d.state = ST_HOT;
                    else if (!reg_f)              nxt_d.state = ST_START;
                end
                ST_HOT: begin
                    if (stop_fall)   nxt_d.state = ST_HALT;
                    else if (cool_f) nxt_d.state = ST_START;
                end
                ST_HALT:  nxt_d.state = ST_HALT;
                default:  nxt_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{state: ST_IDLE, stop_prev: 1'b0};
        else        cur_q <= nxt_d;
    end

    assign su_en_o    = (cur_q.state == ST_START);
    assign main_en_o  = (cur_q.state == ST_RUN);
    assign soft_lim_o = (cur_q.state == ST_START);
    assign sw_off_o   = ~(su_en_o | main_en_o);
endmodule

// File: rtl/conv_start_supervisor.sv
module conv_start_supervisor
    import conv_sup_pkg::*;
#(
    parameter int FILT_LEN = 4,
    parameter int LEN_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bat_ok_i,
    input  logic             reg_ok_i,
    input  logic             above_stop_i,
    input  logic             hot_i,
    input  logic             cool_i,
    input  logic             shdn_i,
    input  logic             pwm_mode_i,
    input  logic [LEN_W-1:0] su_on_len_i,
    input  logic [LEN_W-1:0] su_off_len_i,
    output logic             su_en_o,
    output logic             main_en_o,
    output logic             sw_off_o,
    output logic             soft_lim_o,
    output logic             su_pulse_o
);
    logic [NUM_FLAGS-1:0] raw_flags;
    logic [NUM_FLAGS-1:0] flt_flags;

    always_comb begin
        raw_flags          = '0;
        raw_flags[FL_BAT]  = bat_ok_i;
        raw_flags[FL_REG]  = reg_ok_i;
        raw_flags[FL_STOP] = above_stop_i;
        raw_flags[FL_HOT]  = hot_i;
        raw_flags[FL_COOL] = cool_i;
    end

    for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_filt
        sup_flag_filter #(.LEN(FILT_LEN)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw_flags[gi]),
            .flt_o (flt_flags[gi])
        );
    end

    sup_state_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .flags_i    (flt_flags),
        .shdn_i     (shdn_i),
        .pwm_mode_i (pwm_mode_i),
        .su_en_o    (su_en_o),
        .main_en_o  (main_en_o),
        .sw_off_o   (sw_off_o),
        .soft_lim_o (soft_lim_o)
    );

    sup_pulse_gen #(.LEN_W(LEN_W)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (su_en_o),
        .gate_i    (main_en_o),
        .on_len_i  (su_on_len_i),
        .off_len_i (su_off_len_i),
        .pulse_o   (su_pulse_o)
    );
endmodule

// File: rtl/conv_start_supervisor_chk.sv
module conv_start_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic shdn_i,
    input logic su_en_o,
    input logic main_en_o,
    input logic sw_off_o,
    input logic soft_lim_o,
    input logic su_pulse_o
);
    assert_shdn_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_i |=> (sw_off_o && !su_en_o && !main_en_o && !su_pulse_o));

    assert_no_direct_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shdn_i) |=> !main_en_o);

    assert_handover_from_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_en_o) |-> $past(su_en_o));

    assert_pulse_in_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        su_pulse_o |-> (su_en_o && !main_en_o));

    assert_soft_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        su_en_o |-> (soft_lim_o && !sw_off_o));
endmodule

bind conv_start_supervisor conv_start_supervisor_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .shdn_i     (shdn_i),
    .su_en_o    (su_en_o),
    .main_en_o  (main_en_o),
    .sw_off_o   (sw_off_o),
    .soft_lim_o (soft_lim_o),
    .su_pulse_o (su_pulse_o)
);

// File: tb/sim_conv_start_supervisor.sv
module sim_conv_start_supervisor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bat, regok, stop, hot, cool, shdn, pwm;
    logic [7:0] on_len, off_len;
    logic su_en, main_en, sw_off, soft_lim, pulse;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    conv_start_supervisor u0 (
        .clk(clk), .rst_n(rst_n), .bat_ok_i(bat), .reg_ok_i(regok),
        .above_stop_i(stop), .hot_i(hot), .cool_i(cool), .shdn_i(shdn),
        .pwm_mode_i(pwm), .su_on_len_i(on_len), .su_off_len_i(off_len),
        .su_en_o(su_en), .main_en_o(main_en), .sw_off_o(sw_off),
        .soft_lim_o(soft_lim), .su_pulse_o(pulse)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        bat = 0; regok = 0; stop = 0; hot = 0; cool = 0; shdn = 0; pwm = 0;
        on_len = 8'd3; off_len = 8'd2;
        rst_n = 0;
        tick(2);
        rst_n = 1;
        tick(1);
    endtask

    task automatic go_run();
        bat = 1; stop = 1; regok = 1; cool = 0;
        tick(12);
    endtask

    task automatic t_reset_R2();
        do_reset();
        chk("R2 sw_off", sw_off, 1);
        chk("R2 su_en", su_en, 0);
        chk("R2 main_en", main_en, 0);
        chk("R2 soft_lim", soft_lim, 0);
        tick(10);
        chk("R2 pulse idle", pulse, 0);
        chk("R2 still idle", su_en, 0);
    endtask

    task automatic t_filter_R1_R3();
        do_reset();
        bat = 1; tick(3); bat = 0; tick(8);
        chk("R1 short run ignored", su_en, 0);
        bat = 1; tick(4);
        chk("R1 not before edge 5", su_en, 0);
        tick(1);
        chk("R1 at edge 5", su_en, 1);
        chk("R3 soft_lim", soft_lim, 1);
        chk("R3 sw_off low", sw_off, 0);
        chk("R3 main_en low", main_en, 0);
        bat = 0; tick(5);
        chk("R3 battery loss to idle", su_en, 0);
        chk("R3 battery loss sw_off", sw_off, 1);
    endtask

    task automatic pulse_seq(input logic [7:0] onl, input logic [7:0] offl,
                             input logic [9:0] exp, input string tag);
        do_reset();
        on_len = onl; off_len = offl;
        bat = 1;
        for (int i = 0; i < 20 && su_en !== 1'b1; i++) tick(1);
        for (int k = 0; k < 10; k++) begin
            chk(tag, pulse, exp[9-k]);
            tick(1);
        end
    endtask

    task automatic t_pulse_R4();
        pulse_seq(8'd3, 8'd2, 10'b1110011100, "R4 pulse 3/2");
        pulse_seq(8'd1, 8'd0, 10'b1010101010, "R4 pulse 1/0");
        bat = 0; tick(6);
        chk("R4 pulse off outside start", pulse, 0);
    endtask

    task automatic t_handover_R5_R6();
        do_reset();
        bat = 1; stop = 1; tick(6);
        regok = 1; tick(4);
        chk("R5 still start", su_en, 1);
        chk("R5 not yet main", main_en, 0);
        tick(1);
        chk("R5 main_en", main_en, 1);
        chk("R5 su_en", su_en, 0);
        chk("R5 soft_lim", soft_lim, 0);
        chk("R5 pulse gated", pulse, 0);
        chk("R5 sw_off", sw_off, 0);
        regok = 0; tick(5);
        chk("R6 back to start", su_en, 1);
        chk("R6 main_en off", main_en, 0);
    endtask

    task automatic t_stop_R7_R9();
        do_reset();
        go_run();
        chk("R7 running", main_en, 1);
        stop = 0; tick(5);
        chk("R7 halt sw_off", sw_off, 1);
        chk("R7 halt main_en", main_en, 0);
        chk("R7 halt su_en", su_en, 0);
        stop = 1; cool = 1; tick(12);
        chk("R7 halt sticky", sw_off, 1);
        shdn = 1; tick(1); shdn = 0;
        tick(1);
        chk("R9 idle after release", main_en, 0);
        tick(1);
        chk("R9 start after release", su_en, 1);
        chk("R9 no direct run", main_en, 0);
        tick(1);
        chk("R9 run afterwards", main_en, 1);
    endtask

    task automatic t_shutdown_R8_R10();
        do_reset();
        go_run();
        shdn = 1; tick(1);
        chk("R8 sw_off", sw_off, 1);
        chk("R8 main_en", main_en, 0);
        chk("R8 su_en", su_en, 0);
        chk("R8 pulse", pulse, 0);
        do_reset();
        shdn = 1; tick(1);
        bat = 1; tick(8);
        chk("R8 held in shutdown", sw_off, 1);
        shdn = 0; tick(1);
        chk("R10 idle first", su_en, 0);
        tick(1);
        chk("R10 start at second edge", su_en, 1);
    endtask

    task automatic t_thermal_R11_R12();
        do_reset();
        pwm = 0;
        go_run();
        hot = 1; tick(10);
        chk("R11 ignored without pwm", main_en, 1);
        hot = 0; tick(6);
        pwm = 1; hot = 1; tick(5);
        chk("R11 thermal halt sw_off", sw_off, 1);
        chk("R11 thermal halt main_en", main_en, 0);
        chk("R11 thermal halt su_en", su_en, 0);
        hot = 0; tick(10);
        chk("R12 hot clear not enough", sw_off, 1);
        cool = 1; tick(5);
        chk("R12 cooled to start", su_en, 1);
    endtask

    task automatic t_priority_R13();
        do_reset();
        pwm = 1;
        go_run();
        regok = 0; hot = 1; tick(5);
        chk("R13 hot beats reg loss su_en", su_en, 0);
        chk("R13 hot beats reg loss sw_off", sw_off, 1);
        cool = 1; tick(5);
        chk("R13 was thermal halt", su_en, 1);
        do_reset();
        pwm = 1;
        go_run();
        stop = 0; hot = 1; tick(5);
        chk("R13 stop beats hot sw_off", sw_off, 1);
        cool = 1; tick(8);
        chk("R13 was stop halt", su_en, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_reset_R2();
        t_filter_R1_R3();
        t_pulse_R4();
        t_handover_R5_R6();
        t_stop_R7_R9();
        t_shutdown_R8_R10();
        t_thermal_R11_R12();
        t_priority_R13();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule